// File: doc/BRIEF.md
# Polarity-Aware Line Wake-Up Generator

This block produces a wake-up pulse on a bidirectional sensor line. The pulse takes the polarity that opposes the level the line already rests at. Generation is armed when either an external enable pin or a software enable bit goes high. In the first cycle of arming, the block records the present logic level of the line. From then on, a request that takes both transmit inputs from high to low starts the pulse. For a fixed number of clock cycles the block drives the line to the inverse of the recorded level, with the driver enabled. Control then returns to the transmit inputs.

When the block is not pulsing, the transmit data and transmit enable inputs pass straight through to the line driver. Software arms the block before it asks for a wake-up and disarms it afterwards. A one-cycle done flag marks the end of each pulse. Once a pulse has been produced, the block stays spent until the enable has been removed and applied again. The pulse length comes from the clock frequency and the nominal pulse width of 80 µs.

Top module: `wake_pulse_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is disarmed, `wakeDone` is 0, and the driver outputs follow the transmit inputs.
- R2: Whenever no pulse is in progress, `lineDrive` equals `txData` and `lineDriveEn` equals `txEn` in the same cycle.
- R3: The block arms on the first clock edge at which `wakeEnPin | wakeEnBit` is 1 while it is disarmed, and it stores the value of `lineLevel` at that edge. Either enable source alone is enough to arm it.
- R4: A trigger is a clock edge at which the block is armed, both `txData` and `txEn` are 0, and both were 1 at the previous edge. A fall on only one of the two inputs is not a trigger, and neither is a fall at the edge that arms the block.
- R5: During the pulse, `lineDriveEn` is 1 and `lineDrive` is the inverse of the stored level: 0 if the line was stored high, 1 if it was stored low.
- R6: The pulse starts in the cycle after the trigger edge. It lasts exactly PULSE_CYCLES = CLK_FREQ_HZ*PULSE_US/1000000 cycles.
- R7: Once started, the pulse keeps its polarity and full length even if `lineLevel` or either enable changes while it runs.
- R8: `wakeDone` is 1 for exactly one cycle, the cycle right after the last pulse cycle.
- R9: After a pulse, further triggers are ignored until the enable has been 0 at a clock edge and is then applied again. If the enable is 0 at an edge while the block is armed, the block disarms, and this takes priority over a trigger at the same edge.
- R10: A high-to-low request while the block is disarmed produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeEnPin | input | 1 | Wake-up enable from the external pin |
| wakeEnBit | input | 1 | Wake-up enable from the control register bit |
| lineLevel | input | 1 | Sampled logic level of the sensor line |
| txData | input | 1 | Transmit data |
| txEn | input | 1 | Transmit driver enable |
| lineDrive | output | 1 | Value driven onto the line |
| lineDriveEn | output | 1 | Line driver enable |
| wakeDone | output | 1 | One-cycle pulse at the end of a wake-up |

## Verification
Two functions can meet at a single edge. At the edge where an armed block sees the transmit inputs fall, the enable may also drop, so disarming and triggering compete. The bench lowers the enable in the same cycle that it drops both transmit inputs, then expects pass-through values and no pulse. In a second case the enable and the line level change in the middle of a pulse, so the hold on polarity and length meets the disarm path. The bench expects the full pulse with unchanged polarity, then the done flag, then the disarmed state.

// File: rtl/wake_pulse_pkg.sv
package wake_pulse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PULSE = 2'd2,
    ST_SPENT = 2'd3
  } wakeState_e;

  typedef struct packed {
    logic armCapture;
    logic loadCount;
    logic countEn;
    logic pulseActive;
    logic doneStrobe;
  } wakeStrobes_t;

endpackage

// File: rtl/wake_pulse_ctrl.sv
module wake_pulse_ctrl
  import wake_pulse_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wakeEnable,
  input  logic         txFall,
  input  logic         countZero,
  output wakeStrobes_t strobes
);

  wakeState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (wakeEnable) begin
          stateD             = ST_ARMED;
          strobes.armCapture = 1'b1;
        end
      end
      ST_ARMED: begin
        if (!wakeEnable) begin
          stateD = ST_IDLE;
        end else if (txFall) begin
          stateD            = ST_PULSE;
          strobes.loadCount = 1'b1;
        end
      end
      ST_PULSE: begin
        strobes.pulseActive = 1'b1;
        strobes.countEn     = 1'b1;
        if (countZero) begin
          stateD             = ST_SPENT;
          strobes.doneStrobe = 1'b1;
        end
      end
      ST_SPENT: begin
        if (!wakeEnable) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wake_pulse_datapath.sv
module wake_pulse_datapath
  import wake_pulse_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  wakeStrobes_t strobes,
  input  logic         lineLevel,
  input  logic         txData,
  input  logic         txEn,
  output logic         txFall,
  output logic         countZero,
  output logic         lineDrive,
  output logic         lineDriveEn,
  output logic         wakeDone
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

  logic             heldLevel;
  logic             prevBothHigh;
  logic [CNT_W-1:0] remaining;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldLevel    <= 1'b0;
      prevBothHigh <= 1'b0;
      remaining    <= '0;
      doneQ        <= 1'b0;
    end else begin
      prevBothHigh <= txData & txEn;
      doneQ        <= strobes.doneStrobe;
      if (strobes.armCapture) heldLevel <= lineLevel;
      if (strobes.loadCount)
        remaining <= LOAD_VAL;
      else if (strobes.countEn && !countZero)
        remaining <= remaining - 1'b1;
    end
  end

  assign countZero   = (remaining == '0);
  assign txFall      = prevBothHigh & ~txData & ~txEn;
  assign lineDrive   = strobes.pulseActive ? ~heldLevel : txData;
  assign lineDriveEn = strobes.pulseActive | txEn;
  assign wakeDone    = doneQ;

endmodule

// File: rtl/wake_pulse_gen.sv
module wake_pulse_gen
  import wake_pulse_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 24_000_000,
  parameter int unsigned PULSE_US    = 80
) (
  input  logic clk,
  input  logic rstN,
  input  logic wakeEnPin,
  input  logic wakeEnBit,
  input  logic lineLevel,
  input  logic txData,
  input  logic txEn,
  output logic lineDrive,
  output logic lineDriveEn,
  output logic wakeDone
);

  localparam longint unsigned PRODUCT = longint'(CLK_FREQ_HZ) * longint'(PULSE_US);
  localparam int unsigned PULSE_CYCLES = int'(PRODUCT / 64'd1_000_000);

  wakeStrobes_t strobes;
  logic         txFall;
  logic         countZero;
  logic         pulseActive;

  assign pulseActive = strobes.pulseActive;

  wake_pulse_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wakeEnable (wakeEnPin | wakeEnBit),
    .txFall     (txFall),
    .countZero  (countZero),
    .strobes    (strobes)
  );

  wake_pulse_datapath #(.PULSE_CYCLES(PULSE_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lineLevel   (lineLevel),
    .txData      (txData),
    .txEn        (txEn),
    .txFall      (txFall),
    .countZero   (countZero),
    .lineDrive   (lineDrive),
    .lineDriveEn (lineDriveEn),
    .wakeDone    (wakeDone)
  );

endmodule

// File: rtl/wake_pulse_checker.sv
module wake_pulse_checker #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic wakeEnPin,
  input logic wakeEnBit,
  input logic txData,
  input logic txEn,
  input logic pulseActive,
  input logic lineDrive,
  input logic lineDriveEn,
  input logic wakeDone
);

  logic [31:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)            runLen <= '0;
    else if (pulseActive) runLen <= runLen + 1;
    else                  runLen <= '0;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !pulseActive |-> (lineDrive == txData && lineDriveEn == txEn)); // R2

  AST_PULSE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> lineDriveEn); // R5

  AST_POLARITY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && $past(pulseActive)) |-> $stable(lineDrive)); // R7

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseActive) |-> (runLen == PULSE_CYCLES)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |=> !wakeDone); // R8

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> ($past(pulseActive) && !pulseActive)); // R8

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(wakeEnPin || wakeEnBit)); // R9

endmodule

bind wake_pulse_gen wake_pulse_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .wakeEnPin   (wakeEnPin),
  .wakeEnBit   (wakeEnBit),
  .txData      (txData),
  .txEn        (txEn),
  .pulseActive (pulseActive),
  .lineDrive   (lineDrive),
  .lineDriveEn (lineDriveEn),
  .wakeDone    (wakeDone)
);

// File: tb/wake_pulse_gen_tb.sv
module wake_pulse_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned FREQ = 50_000;
  localparam int unsigned WIDTH_US = 80;
  localparam int NCYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeEnPin = 1'b0, wakeEnBit = 1'b0, lineLevel = 1'b0;
  logic txData = 1'b0, txEn = 1'b0;
  logic lineDrive, lineDriveEn, wakeDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic  drv;
    logic  en;
    logic  done;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pulse_gen #(.CLK_FREQ_HZ(FREQ), .PULSE_US(WIDTH_US)) u_dut (
    .clk(clk), .rstN(rstN), .wakeEnPin(wakeEnPin), .wakeEnBit(wakeEnBit),
    .lineLevel(lineLevel), .txData(txData), .txEn(txEn),
    .lineDrive(lineDrive), .lineDriveEn(lineDriveEn), .wakeDone(wakeDone)
  );

  task automatic cyc(input logic pin, input logic bitEn, input logic lvl,
                     input logic td, input logic te,
                     input logic eDrv, input logic eEn, input logic eDone,
                     input string req);
    expItem_t it;
    @(negedge clk);
    wakeEnPin = pin; wakeEnBit = bitEn; lineLevel = lvl;
    txData = td; txEn = te;
    it.drv = eDrv; it.en = eEn; it.done = eDone; it.req = req;
    expQ.push_back(it);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (lineDrive !== it.drv || lineDriveEn !== it.en || wakeDone !== it.done) begin
          errors++;
          $display("FAIL %s: drv/en/done actual %b%b%b expected %b%b%b at %0t",
                   it.req, lineDrive, lineDriveEn, wakeDone,
                   it.drv, it.en, it.done, $time);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin : stimulus
    // R1: reset state with transmit inputs high
    txData = 1'b1; txEn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (lineDrive !== 1'b1 || lineDriveEn !== 1'b1 || wakeDone !== 1'b0) begin
      errors++;
      $display("FAIL R1: drv/en/done actual %b%b%b expected 110", lineDrive, lineDriveEn, wakeDone);
    end
    @(negedge clk);
    rstN = 1'b1;
    cyc(0,0,1, 1,1, 1,1,0, "R1 first cycle");

    // R10 / R2: fall while disarmed gives no pulse
    cyc(0,0,1, 1,1, 1,1,0, "R2");
    cyc(0,0,1, 0,0, 0,0,0, "R10");
    cyc(0,0,1, 1,0, 1,0,0, "R2 pass");

    // R3 pin arms with line high; R4 fall on arming edge ignored
    cyc(0,0,1, 1,1, 1,1,0, "R2");
    cyc(1,0,1, 0,0, 0,0,0, "R4 arm edge");
    cyc(1,0,1, 1,1, 1,1,0, "R3");
    cyc(1,0,1, 0,1, 0,1,0, "R4 partial");
    cyc(1,0,1, 1,1, 1,1,0, "R3");
    // trigger: line stored high -> drive low; line changes mid pulse
    cyc(1,0,0, 0,0, 0,1,0, "R5 low pulse");
    for (int i = 1; i < NCYC; i++) cyc(1,0,i%2, 0,0, 0,1,0, "R6 R7");
    cyc(1,0,0, 1,1, 1,1,1, "R8 done");
    // R9 spent: retrigger ignored
    cyc(1,0,0, 1,1, 1,1,0, "R8 single");
    cyc(1,0,0, 0,0, 0,0,0, "R9 spent");
    cyc(0,0,0, 0,0, 0,0,0, "R9 disarm");

    // R3 bit arms with line low -> drive high; enable dropped mid pulse
    cyc(0,1,0, 1,1, 1,1,0, "R3 bit");
    cyc(0,1,1, 0,0, 1,1,0, "R5 high pulse");
    for (int i = 1; i < NCYC; i++) cyc(0,0,0, 0,0, 1,1,0, "R7 enable low");
    cyc(0,0,0, 0,0, 0,0,1, "R8 done");
    cyc(0,0,0, 1,1, 1,1,0, "R9 idle");
    cyc(0,0,0, 0,0, 0,0,0, "R10 disarmed");

    // R9 disarm wins over simultaneous trigger
    cyc(1,0,1, 1,1, 1,1,0, "R3");
    cyc(1,0,1, 1,1, 1,1,0, "R3");
    cyc(0,0,1, 0,0, 0,0,0, "R9 priority");
    cyc(0,0,1, 1,1, 1,1,0, "R2");
    cyc(0,0,1, 0,0, 0,0,0, "R10");

    // R9 re-arm after spent produces a new pulse
    cyc(0,1,1, 1,1, 1,1,0, "R9 rearm");
    cyc(0,1,1, 0,0, 0,1,0, "R6 start");
    for (int i = 1; i < NCYC; i++) cyc(0,1,1, 0,0, 0,1,0, "R6 width");
    cyc(0,1,1, 0,0, 0,0,1, "R6 end R8");
    cyc(0,1,1, 0,0, 0,0,0, "R8");

    repeat (3) @(posedge clk);
    #3;
    finishRun();
  end

endmodule